// File: doc/BRIEF.md
# Privilege Mode and Stack Selection Unit

This unit holds the 16-bit processor status word and derives the current privilege level from its supervisor flag, bit 13. It owns the two physical stack pointers, one for supervisor mode and one for user mode. It steers every read and write of address register seven to the one that matches the active level. The same level tags every bus access with a three-bit classification code.

Each cycle the unit accepts one decoded operation class with a data word, an exception-entry strobe, and a write port for address register seven. In user mode, privileged operations are turned into a one-cycle trap request and have no other effect. Exception entry saves the status word and forces supervisor mode. Status-register writes and return-from-exception can lower the level. After a status-register write, the unit asks for the following instruction to be fetched again and supplies the program code of the level that was in force before the write.

Top module: `priv_stack_unit`

## Requirements
- R1: After reset the status word is 16'h2000, so supervisor mode is active. Both stack pointers read zero, and no trap or refetch is pending.
- R2: Reads and writes of address register seven reach the supervisor stack pointer when bit 13 is 1 and the user stack pointer when it is 0. A write takes effect at the next clock edge.
- R3: `fc_o` is {S, acc_prog_i, !acc_prog_i}. That gives 3'b001 for user data, 3'b010 for user program, 3'b101 for supervisor data and 3'b110 for supervisor program.
- R4: Any operation class from 1 to 8 issued in user mode raises a trap. The classes are 1 halt, 2 bus reset, 3 load SR, 4 AND SR, 5 XOR SR, 6 load USP, 7 read USP and 8 return from exception. The trap appears as `trap_o` high with `trap_vec_o` = 8 for exactly the next cycle. The status word and both stack pointers stay unchanged, including a register-seven write issued in the same cycle.
- R5: When `exc_i` is high, the next cycle shows `saved_sr_o` equal to the prior status word and the status word with bit 13 set and all other bits kept. Any operation issued in that cycle is ignored.
- R6: In supervisor mode, class 3 loads `op_data_i[15:0]` into the status word. Class 4 ANDs that field into it and class 5 XORs that field into it. The result is visible on the next cycle.
- R7: The cycle after any class 3, 4 or 5 write shows `refetch_o` high and `refetch_fc_o` equal to the program code of the old level. This holds even when bit 13 did not change.
- R8: Class 8 in supervisor mode loads `op_data_i[15:0]` as the new status word. The following cycles use the new level, and no refetch is requested.
- R9: Once in user mode, the level returns to supervisor only through `exc_i`.
- R10: Class 6 in supervisor mode loads `op_data_i` into the user stack pointer. `usp_rdata_o` always shows the user stack pointer.
- R11: Operation inputs are ignored while `op_valid_i` is low, and class 0 has no effect in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid_i | input | 1 | Operation class is valid this cycle |
| op_class_i | input | 4 | Decoded operation class |
| op_data_i | input | 32 | Status data, mask or user stack value |
| exc_i | input | 1 | Exception entry strobe |
| a7_wr_i | input | 1 | Write to address register seven |
| a7_wdata_i | input | 32 | Data for address register seven |
| acc_prog_i | input | 1 | Current access is a program fetch |
| s_mode_o | output | 1 | Supervisor mode active |
| sr_o | output | 16 | Status word |
| saved_sr_o | output | 16 | Status word captured at exception entry |
| a7_rdata_o | output | 32 | Address register seven as seen in current mode |
| usp_rdata_o | output | 32 | User stack pointer |
| fc_o | output | 3 | Bus cycle classification |
| trap_o | output | 1 | Privilege violation trap request |
| trap_vec_o | output | 8 | Trap vector number |
| refetch_o | output | 1 | Refetch of next instruction requested |
| refetch_fc_o | output | 3 | Classification for the refetch in the old level |

## Verification
The status word is driven through identity-preserving AND masks, bit-flipping XOR masks and full loads. This separates the three update rules and shows that a refetch occurs even when the level stays the same. Every privileged class is tried in user mode, and one attempt carries a simultaneous register-seven write. Each violation must leave both stack pointers and the status word untouched. Register-seven traffic alternates between modes so the two physical pointers are told apart. Exceptions coincide with status-load attempts so the strobe's priority is visible.

// File: rtl/priv_pkg.sv
package priv_pkg;
    typedef enum logic [3:0] {
        OPC_PLAIN   = 4'd0,
        OPC_HALT    = 4'd1,
        OPC_BUSRST  = 4'd2,
        OPC_SR_LOAD = 4'd3,
        OPC_SR_AND  = 4'd4,
        OPC_SR_XOR  = 4'd5,
        OPC_USP_SET = 4'd6,
        OPC_USP_GET = 4'd7,
        OPC_EXC_RET = 4'd8
    } op_cls_e;

    localparam logic [7:0] PRIV_TRAP_VEC = 8'd8;

    function automatic logic is_priv(input logic [3:0] op);
        return (op >= 4'd1) && (op <= 4'd8);
    endfunction

    function automatic logic is_sr_write(input logic [3:0] op);
        return (op == OPC_SR_LOAD) || (op == OPC_SR_AND) || (op == OPC_SR_XOR);
    endfunction
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
    import priv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SR_W   = 16,
    parameter int S_POS  = 13,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [3:0]        op_class_i,
    input  logic [DATA_W-1:0] op_data_i,
    input  logic              exc_i,
    output logic [SR_W-1:0]   sr_o,
    output logic [SR_W-1:0]   saved_o,
    output logic              s_o,
    output logic              trap_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              refetch_o,
    output logic [2:0]        refetch_fc_o,
    output logic              viol_o,
    output logic              usp_load_o
);
    localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << S_POS;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic [SR_W-1:0] saved;
        logic            trap;
        logic            refetch;
        logic [2:0]      rfc;
    } st_t;

    st_t st_d, st_q;
    logic [SR_W-1:0] imm;
    logic            s_cur;

    assign imm   = op_data_i[SR_W-1:0];
    assign s_cur = st_q.sr[S_POS];

    always_comb begin
        st_d         = st_q;
        st_d.trap    = 1'b0;
        st_d.refetch = 1'b0;
        viol_o       = 1'b0;
        usp_load_o   = 1'b0;
        if (exc_i) begin
            st_d.saved     = st_q.sr;
            st_d.sr[S_POS] = 1'b1;
        end else if (op_valid_i) begin
            if (!s_cur && is_priv(op_class_i)) begin
                viol_o    = 1'b1;
                st_d.trap = 1'b1;
            end else begin
                case (op_class_i)
                    OPC_SR_LOAD: st_d.sr = imm;
                    OPC_SR_AND:  st_d.sr = st_q.sr & imm;
                    OPC_SR_XOR:  st_d.sr = st_q.sr ^ imm;
                    OPC_EXC_RET: st_d.sr = imm;
                    OPC_USP_SET: usp_load_o = 1'b1;
                    default: ;
                endcase
                if (is_sr_write(op_class_i)) begin
                    st_d.refetch = 1'b1;
                    st_d.rfc     = {s_cur, 2'b10};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sr: SR_RESET, saved: '0, trap: 1'b0, refetch: 1'b0, rfc: 3'b110};
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o         = st_q.sr;
    assign saved_o      = st_q.saved;
    assign s_o          = s_cur;
    assign trap_o       = st_q.trap;
    assign vec_o        = st_q.trap ? PRIV_TRAP_VEC : '0;
    assign refetch_o    = st_q.refetch;
    assign refetch_fc_o = st_q.rfc;

    // R4: user-mode privileged class traps and leaves the status word alone
    p_user_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !exc_i && !s_cur && is_priv(op_class_i))
        |=> (trap_o && $stable(sr_o)));

    // R5: exception entry saves old word and raises supervisor level
    p_exc_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> (s_o && saved_o == $past(sr_o)));

    // R9: user mode is left only through exception entry
    p_user_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_cur && !exc_i) |=> !s_o);

    // R7: a status write in supervisor mode requests a refetch tagged with the old level
    p_refetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !exc_i && s_cur && is_sr_write(op_class_i))
        |=> (refetch_o && refetch_fc_o == 3'b110));
endmodule

// File: rtl/stack_bank.sv
module stack_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_mode_i,
    input  logic              a7_wr_i,
    input  logic [DATA_W-1:0] a7_wdata_i,
    input  logic              usp_load_i,
    input  logic [DATA_W-1:0] usp_ldata_i,
    output logic [DATA_W-1:0] a7_rdata_o,
    output logic [DATA_W-1:0] usp_rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ssp;
        logic [DATA_W-1:0] usp;
    } sp_t;

    sp_t sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (usp_load_i) sp_d.usp = usp_ldata_i;
        if (a7_wr_i) begin
            if (s_mode_i) sp_d.ssp = a7_wdata_i;
            else          sp_d.usp = a7_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign a7_rdata_o  = s_mode_i ? sp_q.ssp : sp_q.usp;
    assign usp_rdata_o = sp_q.usp;

    // R2: the supervisor pointer cannot change while user mode is active
    p_ssp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_mode_i |=> $stable(sp_q.ssp));

    // R10: in supervisor mode the user pointer moves only by an explicit load
    p_usp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_mode_i && !usp_load_i) |=> $stable(usp_rdata_o));
endmodule

// File: rtl/fc_encode.sv
module fc_encode (
    input  logic       s_mode_i,
    input  logic       prog_i,
    output logic [2:0] fc_o
);
    always_comb begin
        fc_o = {s_mode_i, prog_i, !prog_i};
    end
endmodule

// File: rtl/priv_stack_unit.sv
module priv_stack_unit #(
    parameter int DATA_W = 32,
    parameter int SR_W   = 16,
    parameter int S_POS  = 13,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [3:0]        op_class_i,
    input  logic [DATA_W-1:0] op_data_i,
    input  logic              exc_i,
    input  logic              a7_wr_i,
    input  logic [DATA_W-1:0] a7_wdata_i,
    input  logic              acc_prog_i,
    output logic              s_mode_o,
    output logic [SR_W-1:0]   sr_o,
    output logic [SR_W-1:0]   saved_sr_o,
    output logic [DATA_W-1:0] a7_rdata_o,
    output logic [DATA_W-1:0] usp_rdata_o,
    output logic [2:0]        fc_o,
    output logic              trap_o,
    output logic [VEC_W-1:0]  trap_vec_o,
    output logic              refetch_o,
    output logic [2:0]        refetch_fc_o
);
    logic viol, usp_load, s_mode, a7_wr_ok;

    sr_ctrl #(.DATA_W(DATA_W), .SR_W(SR_W), .S_POS(S_POS), .VEC_W(VEC_W)) u_sr (
        .clk(clk), .rst_n(rst_n),
        .op_valid_i(op_valid_i), .op_class_i(op_class_i), .op_data_i(op_data_i),
        .exc_i(exc_i),
        .sr_o(sr_o), .saved_o(saved_sr_o), .s_o(s_mode),
        .trap_o(trap_o), .vec_o(trap_vec_o),
        .refetch_o(refetch_o), .refetch_fc_o(refetch_fc_o),
        .viol_o(viol), .usp_load_o(usp_load)
    );

    assign a7_wr_ok = a7_wr_i && !viol;

    stack_bank #(.DATA_W(DATA_W)) u_sp (
        .clk(clk), .rst_n(rst_n), .s_mode_i(s_mode),
        .a7_wr_i(a7_wr_ok), .a7_wdata_i(a7_wdata_i),
        .usp_load_i(usp_load), .usp_ldata_i(op_data_i),
        .a7_rdata_o(a7_rdata_o), .usp_rdata_o(usp_rdata_o)
    );

    fc_encode u_fc (.s_mode_i(s_mode), .prog_i(acc_prog_i), .fc_o(fc_o));

    assign s_mode_o = s_mode;

    // R3: the classification's top bit follows the privilege level
    p_fc_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fc_o[2] == sr_o[S_POS]);
endmodule

// File: tb/tb_priv_stack_unit.sv
module tb_priv_stack_unit;
    import priv_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_class_i = 4'd0;
    logic [31:0] op_data_i = '0;
    logic        exc_i = 1'b0;
    logic        a7_wr_i = 1'b0;
    logic [31:0] a7_wdata_i = '0;
    logic        acc_prog_i = 1'b0;
    logic        s_mode_o, trap_o, refetch_o;
    logic [15:0] sr_o, saved_sr_o;
    logic [31:0] a7_rdata_o, usp_rdata_o;
    logic [2:0]  fc_o, refetch_fc_o;
    logic [7:0]  trap_vec_o;

    always #2.5 clk = ~clk;

    priv_stack_unit dut (.*);

    typedef struct {
        logic [15:0] sr, saved;
        logic        trap, rf;
        logic [2:0]  rfc, fc;
        logic [31:0] a7, usp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0;
    bit done = 0;

    logic [15:0] m_sr = 16'h2000, m_saved = '0;
    logic [31:0] m_ssp = '0, m_usp = '0;

    function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endfunction

    task automatic step(input logic v, input logic [3:0] op, input logic [31:0] d,
                        input logic exc, input logic wr, input logic [31:0] wd,
                        input logic prog, input string tag);
        exp_t e;
        logic s, viol;
        @(negedge clk);
        op_valid_i = v; op_class_i = op; op_data_i = d; exc_i = exc;
        a7_wr_i = wr; a7_wdata_i = wd; acc_prog_i = prog;
        s = m_sr[13]; viol = 1'b0;
        e.trap = 1'b0; e.rf = 1'b0; e.rfc = 3'b000;
        if (wr && !(v && !exc && !s && is_priv(op))) begin
            if (s) m_ssp = wd; else m_usp = wd;
        end
        if (exc) begin
            m_saved = m_sr; m_sr[13] = 1'b1;
        end else if (v) begin
            if (!s && is_priv(op)) begin
                viol = 1'b1; e.trap = 1'b1;
            end else begin
                case (op)
                    4'd3: m_sr = d[15:0];
                    4'd4: m_sr = m_sr & d[15:0];
                    4'd5: m_sr = m_sr ^ d[15:0];
                    4'd8: m_sr = d[15:0];
                    4'd6: m_usp = d;
                    default: ;
                endcase
                if (op >= 4'd3 && op <= 4'd5) begin
                    e.rf = 1'b1; e.rfc = {s, 2'b10};
                end
            end
        end
        e.sr = m_sr; e.saved = m_saved;
        e.a7 = m_sr[13] ? m_ssp : m_usp; e.usp = m_usp;
        e.fc = {m_sr[13], prog, !prog};
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "sr", 32'(sr_o), 32'(e.sr));
            chk(e.tag, "saved", 32'(saved_sr_o), 32'(e.saved));
            chk(e.tag, "trap", 32'(trap_o), 32'(e.trap));
            chk(e.tag, "vec", 32'(trap_vec_o), e.trap ? 32'd8 : 32'd0);
            chk(e.tag, "refetch", 32'(refetch_o), 32'(e.rf));
            if (e.rf) chk(e.tag, "refetch_fc", 32'(refetch_fc_o), 32'(e.rfc));
            chk(e.tag, "a7", a7_rdata_o, e.a7);
            chk(e.tag, "usp", usp_rdata_o, e.usp);
            chk(e.tag, "fc", 32'(fc_o), 32'(e.fc));
            chk(e.tag, "s_mode", 32'(s_mode_o), 32'(e.sr[13]));
        end
    end

    initial begin
        #50000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 / R11: idle and invalid operation leave reset state
        step(0, 4'd3, 32'h0, 0, 0, 0, 0, "R1");
        step(0, 4'd3, 32'h0000_0000, 0, 0, 0, 1, "R11");
        step(1, 4'd0, 32'hFFFF, 0, 0, 0, 1, "R11");
        // R2: supervisor write lands in supervisor pointer
        step(0, 4'd0, 0, 0, 1, 32'h0000_1000, 0, "R2");
        // R10: load user pointer from supervisor mode
        step(1, 4'd6, 32'h0000_2222, 0, 0, 0, 1, "R10");
        step(1, 4'd7, 32'h0, 0, 0, 0, 0, "R10");
        // R6 / R7: identity AND still refetches
        step(1, 4'd4, 32'hFFFF, 0, 0, 0, 1, "R7");
        step(1, 4'd5, 32'h00FF, 0, 0, 0, 0, "R6");
        // R6 / R7: load drops to user, refetch uses supervisor program code
        step(1, 4'd3, 32'h0005, 0, 0, 0, 1, "R7");
        step(0, 4'd0, 0, 0, 0, 0, 0, "R3");
        // R2: user-mode write lands in user pointer
        step(0, 4'd0, 0, 0, 1, 32'h0000_3333, 1, "R2");
        // R4: every privileged class traps in user mode
        for (int k = 1; k <= 8; k++)
            step(1, 4'(k), 32'h0000_2700, 0, (k == 3), 32'hDEAD_BEEF, 0, "R4");
        // R9 / R11: plain ops keep user level
        step(1, 4'd0, 32'h2000, 0, 0, 0, 1, "R9");
        step(1, 4'd9, 32'h2000, 0, 0, 0, 0, "R9");
        // R5: exception wins over a simultaneous status load
        step(1, 4'd3, 32'h0000, 1, 0, 0, 1, "R5");
        step(0, 4'd0, 0, 0, 1, 32'h0000_4444, 0, "R2");
        // R8: return to user, no refetch
        step(1, 4'd8, 32'h0010, 0, 0, 0, 1, "R8");
        step(0, 4'd0, 0, 0, 0, 0, 0, "R8");
        step(0, 4'd0, 0, 1, 0, 0, 0, "R5");
        step(1, 4'd8, 32'h2700, 0, 0, 0, 1, "R8");
        step(1, 4'd5, 32'h2000, 0, 0, 0, 1, "R7");
        step(0, 4'd0, 0, 0, 0, 0, 1, "R3");
        step(0, 4'd0, 0, 1, 0, 0, 0, "R5");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule